// File: doc/BRIEF.md
# Parallel NOR Flash Reset and Bus-Width Front End

This block is the control front end of a behavioural parallel NOR flash model. It watches the active-low hardware reset pin and qualifies it with cycle counters. A low pulse shorter than the minimum width has no effect. A pulse that lasts long enough aborts any embedded program or erase in progress and returns the internal state machine to read mode after a ready interval. After the pin is released, the front end refuses bus access for a recovery interval. If the reset lands during an embedded operation, the address of that operation is recorded as corrupted.

On the bus side, the block maps the 16 data lines for the two widths. When the width select is high, reads drive all 16 lines. When it is low, reads are one byte wide: the top data line is taken as the least significant address bit, and lines 8 to 15 are left undriven. The command byte always comes from the low eight lines, in either width. The array, the embedded algorithms and all electrical levels live outside this block.

Top module: `nor_ctl_front`

## Requirements
- R1: A reset pin low for fewer than T_RP consecutive sampled clock edges does not reset anything: after release an embedded operation stays busy, `embed_abort` stays 0, `corrupt_flag` is unchanged, and `access_ok` is 1 on the first edge that samples the pin high.
- R2: When the pin is sampled low at T_RP consecutive edges, the reset is qualified at the T_RP-th edge. At that edge `embed_busy` clears, and if an operation was busy `embed_abort` is 1 for exactly the following cycle.
- R3: `sm_ready` is 0 for exactly T_READY cycles after the qualifying edge and then returns to 1.
- R4: `access_ok` is 0 while the pin is sampled low and after a qualified reset. Once the ready interval is over and the pin is seen high, `access_ok` rises at the T_RH-th edge that samples it high.
- R5: While the reset pin is low, `dq_oe` is all zeros, combinationally and with no clock delay.
- R6: A qualified reset that hits a busy operation sets `corrupt_flag` and loads `corrupt_addr` with the byte address captured when that operation started. A qualified reset while idle leaves both unchanged.
- R7: When `word_mode` is 1, a permitted read drives `dq_out = arr_rdata` with `dq_oe = 16'hFFFF`, and `arr_addr = {a_in, 1'b0}`.
- R8: When `word_mode` is 0, `arr_addr = {a_in, dq_in[15]}` and a permitted read drives only lanes 0 to 7 (`dq_oe = 16'h00FF`). Those lanes carry `arr_rdata[15:8]` when `dq_in[15]` is 1 and `arr_rdata[7:0]` otherwise. Undriven lanes read 0 on `dq_out`.
- R9: `cmd_byte` always equals `dq_in[7:0]` in both widths. `wr_data` equals `dq_in` in word mode and `{8'h00, dq_in[7:0]}` in byte mode. `cmd_valid = wr_req` only while access is permitted.
- R10: While `access_ok` is 0, `rd_req` drives no lane and `wr_req` raises no `cmd_valid`.
- R11: `embed_start` is accepted only when access is permitted and no operation is busy. Otherwise it is ignored, and the captured address keeps the earlier value.
- R12: After the system reset `rst_n`: `sm_ready = 1`, `access_ok = 1`, `embed_busy = 0`, `embed_abort = 0`, `corrupt_flag = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rst_pin_n | input | 1 | Flash hardware reset pin, active low |
| word_mode | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| a_in | input | AW | Word address pins |
| dq_in | input | 16 | Data pins as seen from the host |
| dq_out | output | 16 | Read data driven by the device |
| dq_oe | output | 16 | Per-lane drive enable |
| rd_req | input | 1 | Output enable asserted by the host |
| wr_req | input | 1 | Write strobe from the host |
| arr_rdata | input | 16 | Word read from the array model |
| arr_addr | output | AW+1 | Byte address toward the array |
| cmd_valid | output | 1 | Accepted write cycle |
| cmd_byte | output | 8 | Command byte, always the low lanes |
| wr_data | output | 16 | Program data for the current width |
| embed_start | input | 1 | Engine starts an embedded operation at `arr_addr` |
| embed_done | input | 1 | Engine finished the operation |
| embed_busy | output | 1 | Embedded operation in progress |
| embed_abort | output | 1 | One-cycle abort notice to the engine |
| sm_ready | output | 1 | State machine is back in read mode |
| access_ok | output | 1 | Bus access permitted |
| corrupt_flag | output | 1 | A location was corrupted by reset |
| corrupt_addr | output | AW+1 | Byte address of that location |

## Verification
The hardest case to reach is the boundary between a pulse of T_RP-1 edges and a pulse of T_RP edges while an embedded operation is busy. A pulse one edge too short has to leave no trace, while the full-width pulse has to abort the operation and record the corrupted address. The stimulus starts an operation and then holds the pin low for exactly those two counts. It then holds the pin through the ready interval, releases it, and probes reads and writes on every recovery cycle. Random reads and writes in both widths exercise lane selection between these directed phases.

// File: rtl/nfe_pkg.sv
`timescale 1ns/1ps
package nfe_pkg;
  localparam int DQ_W   = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_RUN   = 3'd0,
    S_LOW   = 3'd1,
    S_READY = 3'd2,
    S_HELD  = 3'd3,
    S_REC   = 3'd4
  } rst_state_e;
endpackage

// File: rtl/nfe_rst_seq.sv
`timescale 1ns/1ps
module nfe_rst_seq
  import nfe_pkg::*;
#(
  parameter int unsigned T_RP    = 8,
  parameter int unsigned T_RH    = 5,
  parameter int unsigned T_READY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic qualify,
  output logic sm_ready,
  output logic access_ok
);
  localparam int unsigned T_M1  = (T_RP > T_RH) ? T_RP : T_RH;
  localparam int unsigned T_MAX = (T_M1 > T_READY) ? T_M1 : T_READY;
  localparam int unsigned CW    = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RH_LAST  = CW'(T_RH - 1);
  localparam logic [CW-1:0] RDY_LAST = CW'(T_READY - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  rst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    qualify = 1'b0;
    unique case (state_q)
      S_RUN: begin
        if (!pin_n) begin
          state_d = S_LOW;
          cnt_d   = ONE;
        end
      end
      S_LOW: begin
        if (pin_n) begin
          state_d = S_RUN;
          cnt_d   = '0;
        end else if (cnt_q == RP_LAST) begin
          qualify = 1'b1;
          state_d = S_READY;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      S_READY: begin
        if (cnt_q == RDY_LAST) begin
          state_d = S_HELD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      S_HELD: begin
        if (pin_n) begin
          state_d = S_REC;
          cnt_d   = ONE;
        end
      end
      S_REC: begin
        if (!pin_n) begin
          state_d = S_LOW;
          cnt_d   = ONE;
        end else if (cnt_q == RH_LAST) begin
          state_d = S_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        state_d = S_RUN;
        cnt_d   = '0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sm_ready  = (state_q != S_READY);
  assign access_ok = (state_q == S_RUN);
endmodule

// File: rtl/nfe_lane_map.sv
`timescale 1ns/1ps
module nfe_lane_map
  import nfe_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic              word_mode,
  input  logic              bus_ok,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [AW-1:0]     a_in,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic [DQ_W-1:0]   arr_rdata,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe,
  output logic [AW:0]       arr_addr,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [DQ_W-1:0]   wr_data
);
  logic rd_en;
  logic lsb;

  assign rd_en    = rd_req & bus_ok;
  assign lsb      = word_mode ? 1'b0 : dq_in[DQ_W-1];
  assign arr_addr = {a_in, lsb};

  // low lanes: in byte mode pick the half selected by the borrowed address bit
  // high lanes: driven only in word mode
  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    if (i < BYTE_W) begin : g_lo
      logic val;
      assign val       = (word_mode || !lsb) ? arr_rdata[i] : arr_rdata[i+BYTE_W];
      assign dq_oe[i]  = rd_en;
      assign dq_out[i] = rd_en & val;
    end else begin : g_hi
      assign dq_oe[i]  = rd_en & word_mode;
      assign dq_out[i] = rd_en & word_mode & arr_rdata[i];
    end
  end

  assign cmd_valid = wr_req & bus_ok;
  assign cmd_byte  = dq_in[BYTE_W-1:0];
  assign wr_data   = word_mode ? dq_in : {{(DQ_W-BYTE_W){1'b0}}, dq_in[BYTE_W-1:0]};
endmodule

// File: rtl/nfe_op_track.sv
`timescale 1ns/1ps
module nfe_op_track #(
  parameter int unsigned AW = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_ok,
  input  logic        embed_start,
  input  logic        embed_done,
  input  logic [AW:0] op_addr,
  input  logic        qualify,
  output logic        embed_busy,
  output logic        embed_abort,
  output logic        corrupt_flag,
  output logic [AW:0] corrupt_addr
);
  logic        busy_q, busy_d;
  logic        abort_q, abort_d;
  logic        cflag_q, cflag_d;
  logic        accept;
  logic        hit;
  logic [AW:0] addr_q;
  logic [AW:0] caddr_q;

  assign accept = embed_start & bus_ok & ~busy_q;
  assign hit    = qualify & busy_q;

  always_comb begin
    busy_d  = busy_q;
    abort_d = hit;
    cflag_d = cflag_q | hit;
    if (qualify || embed_done) begin
      busy_d = 1'b0;
    end else if (accept) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
      cflag_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      abort_q <= abort_d;
      cflag_q <= cflag_d;
    end
  end

  // address capture registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept && !qualify) begin
      addr_q <= op_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q <= '0;
    end else if (hit) begin
      caddr_q <= addr_q;
    end
  end

  assign embed_busy   = busy_q;
  assign embed_abort  = abort_q;
  assign corrupt_flag = cflag_q;
  assign corrupt_addr = caddr_q;
endmodule

// File: rtl/nor_ctl_front.sv
`timescale 1ns/1ps
module nor_ctl_front
  import nfe_pkg::*;
#(
  parameter int unsigned AW      = 20,
  parameter int unsigned T_RP    = 8,
  parameter int unsigned T_RH    = 5,
  parameter int unsigned T_READY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin_n,
  input  logic              word_mode,
  input  logic [AW-1:0]     a_in,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [DQ_W-1:0]   arr_rdata,
  output logic [AW:0]       arr_addr,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [DQ_W-1:0]   wr_data,
  input  logic              embed_start,
  input  logic              embed_done,
  output logic              embed_busy,
  output logic              embed_abort,
  output logic              sm_ready,
  output logic              access_ok,
  output logic              corrupt_flag,
  output logic [AW:0]       corrupt_addr
);
  logic qualify;
  logic bus_ok;

  // pin low forces standby at once, independent of the sampled state
  assign bus_ok = access_ok & rst_pin_n;

  nfe_rst_seq #(.T_RP(T_RP), .T_RH(T_RH), .T_READY(T_READY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (rst_pin_n),
    .qualify   (qualify),
    .sm_ready  (sm_ready),
    .access_ok (access_ok)
  );

  nfe_lane_map #(.AW(AW)) u_map (
    .word_mode (word_mode),
    .bus_ok    (bus_ok),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .a_in      (a_in),
    .dq_in     (dq_in),
    .arr_rdata (arr_rdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .arr_addr  (arr_addr),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .wr_data   (wr_data)
  );

  nfe_op_track #(.AW(AW)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ok       (bus_ok),
    .embed_start  (embed_start),
    .embed_done   (embed_done),
    .op_addr      (arr_addr),
    .qualify      (qualify),
    .embed_busy   (embed_busy),
    .embed_abort  (embed_abort),
    .corrupt_flag (corrupt_flag),
    .corrupt_addr (corrupt_addr)
  );
endmodule

// File: rtl/nfe_front_chk.sv
`timescale 1ns/1ps
module nfe_front_chk #(
  parameter int unsigned AW = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_pin_n,
  input logic        word_mode,
  input logic [15:0] dq_oe,
  input logic        cmd_valid,
  input logic        embed_start,
  input logic        embed_done,
  input logic        embed_busy,
  input logic        embed_abort,
  input logic        sm_ready,
  input logic        access_ok,
  input logic        corrupt_flag
);
  assert_standby_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |-> (dq_oe == 16'h0000));

  assert_byte_upper_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (dq_oe[15:8] == 8'h00));

  assert_no_cmd_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ok |-> !cmd_valid);

  assert_ready_gates_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sm_ready |-> !access_ok);

  assert_busy_end_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(embed_busy) |-> (embed_abort || $past(embed_done)));

  assert_corrupt_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corrupt_flag) |-> ($past(embed_busy) && embed_abort));

  assert_start_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(embed_busy) |-> ($past(embed_start) && $past(access_ok) && $past(rst_pin_n)));

  assert_access_pin_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ok) |-> $past(rst_pin_n));
endmodule

bind nor_ctl_front nfe_front_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_pin_n    (rst_pin_n),
  .word_mode    (word_mode),
  .dq_oe        (dq_oe),
  .cmd_valid    (cmd_valid),
  .embed_start  (embed_start),
  .embed_done   (embed_done),
  .embed_busy   (embed_busy),
  .embed_abort  (embed_abort),
  .sm_ready     (sm_ready),
  .access_ok    (access_ok),
  .corrupt_flag (corrupt_flag)
);

// File: tb/sim_nor_ctl_front.sv
`timescale 1ns/1ps
module sim_nor_ctl_front;
  localparam int AW = 20;
  localparam int TRP = 8;
  localparam int TRH = 5;
  localparam int TRDY = 4;

  logic clk = 1'b0;
  logic rst_n, rst_pin_n, word_mode, rd_req, wr_req, embed_start, embed_done;
  logic [AW-1:0] a_in;
  logic [15:0] dq_in, arr_rdata, dq_out, dq_oe, wr_data;
  logic [AW:0] arr_addr, corrupt_addr;
  logic cmd_valid, embed_busy, embed_abort, sm_ready, access_ok, corrupt_flag;
  logic [7:0] cmd_byte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nor_ctl_front #(.AW(AW), .T_RP(TRP), .T_RH(TRH), .T_READY(TRDY)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .word_mode(word_mode),
    .a_in(a_in), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_req(rd_req), .wr_req(wr_req), .arr_rdata(arr_rdata), .arr_addr(arr_addr),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .wr_data(wr_data),
    .embed_start(embed_start), .embed_done(embed_done), .embed_busy(embed_busy),
    .embed_abort(embed_abort), .sm_ready(sm_ready), .access_ok(access_ok),
    .corrupt_flag(corrupt_flag), .corrupt_addr(corrupt_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  function automatic logic [15:0] exp_oe(input logic wm, input logic rd, input logic ok);
    if (!(rd && ok)) return 16'h0000;
    return wm ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_out(input logic wm, input logic rd, input logic ok,
                                          input logic [15:0] dq, input logic [15:0] rdat);
    if (!(rd && ok)) return 16'h0000;
    if (wm) return rdat;
    return {8'h00, dq[15] ? rdat[15:8] : rdat[7:0]};
  endfunction

  function automatic logic [AW:0] exp_addr(input logic wm, input logic [AW-1:0] a,
                                           input logic [15:0] dq);
    return {a, wm ? 1'b0 : dq[15]};
  endfunction

  // start an operation at a given address
  task automatic start_op(input logic wm, input logic [AW-1:0] a, input logic [15:0] dq);
    word_mode = wm; a_in = a; dq_in = dq;
    embed_start = 1'b1;
    step();
    embed_start = 1'b0;
  endtask

  task automatic random_bus(input int n);
    for (int i = 0; i < n; i++) begin
      word_mode = $urandom_range(0, 1);
      a_in = AW'($urandom);
      dq_in = 16'($urandom);
      arr_rdata = 16'($urandom);
      rd_req = ($urandom_range(0, 3) != 0);
      wr_req = $urandom_range(0, 1);
      #1;
      check("R7_R8 oe", 32'(dq_oe), 32'(exp_oe(word_mode, rd_req, 1'b1)));
      check("R7_R8 out", 32'(dq_out), 32'(exp_out(word_mode, rd_req, 1'b1, dq_in, arr_rdata)));
      check("R7_R8 addr", 32'(arr_addr), 32'(exp_addr(word_mode, a_in, dq_in)));
      check("R9 cmd_byte", 32'(cmd_byte), 32'(dq_in[7:0]));
      check("R9 cmd_valid", 32'(cmd_valid), 32'(wr_req));
      check("R9 wr_data", 32'(wr_data), 32'(word_mode ? dq_in : {8'h00, dq_in[7:0]}));
      step();
    end
    rd_req = 1'b0; wr_req = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW:0] cap;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rst_pin_n = 1'b1; word_mode = 1'b1; rd_req = 1'b0; wr_req = 1'b0;
    embed_start = 1'b0; embed_done = 1'b0; a_in = '0; dq_in = '0; arr_rdata = '0;
    #45;
    rst_n = 1'b1;
    step();
    // R12 reset state
    check("R12 sm_ready", 32'(sm_ready), 32'd1);
    check("R12 access_ok", 32'(access_ok), 32'd1);
    check("R12 busy", 32'(embed_busy), 32'd0);
    check("R12 abort", 32'(embed_abort), 32'd0);
    check("R12 corrupt", 32'(corrupt_flag), 32'd0);

    random_bus(40);

    // R11: start accepted, then a second start while busy is ignored
    start_op(1'b1, 20'h1234A, 16'h0000);
    check("R11 busy", 32'(embed_busy), 32'd1);
    cap = {20'h1234A, 1'b0};
    start_op(1'b1, 20'h0BEEF, 16'h0000);

    // R1: short pulse of TRP-1 low edges
    rst_pin_n = 1'b0;
    rd_req = 1'b1; wr_req = 1'b1; #1;
    check("R5 oe pin low", 32'(dq_oe), 32'd0);
    check("R10 cmd blocked", 32'(cmd_valid), 32'd0);
    for (int i = 0; i < TRP - 1; i++) step();
    check("R4 access low during pulse", 32'(access_ok), 32'd0);
    rst_pin_n = 1'b1; rd_req = 1'b0; wr_req = 1'b0;
    step();
    check("R1 busy kept", 32'(embed_busy), 32'd1);
    check("R1 no abort", 32'(embed_abort), 32'd0);
    check("R1 no corrupt", 32'(corrupt_flag), 32'd0);
    check("R1 access back", 32'(access_ok), 32'd1);
    check("R1 ready", 32'(sm_ready), 32'd1);

    // R2/R3/R6: full pulse
    rst_pin_n = 1'b0;
    for (int i = 0; i < TRP; i++) step();
    check("R2 busy cleared", 32'(embed_busy), 32'd0);
    check("R2 abort", 32'(embed_abort), 32'd1);
    check("R6 flag", 32'(corrupt_flag), 32'd1);
    check("R6 addr first op", 32'(corrupt_addr), 32'(cap));
    check("R3 not ready", 32'(sm_ready), 32'd0);
    step();
    check("R2 abort one cycle", 32'(embed_abort), 32'd0);
    for (int i = 1; i < TRDY - 1; i++) step();
    check("R3 still not ready", 32'(sm_ready), 32'd0);
    step();
    check("R3 ready again", 32'(sm_ready), 32'd1);
    // R11: start while pin held low is ignored
    start_op(1'b1, 20'h00077, 16'h0000);
    check("R11 ignored in reset", 32'(embed_busy), 32'd0);
    step();
    rst_pin_n = 1'b1;
    rd_req = 1'b1; wr_req = 1'b1;
    for (int i = 0; i < TRH - 1; i++) step();
    #1;
    check("R4 recovery access", 32'(access_ok), 32'd0);
    check("R10 no read in recovery", 32'(dq_oe), 32'd0);
    check("R10 no cmd in recovery", 32'(cmd_valid), 32'd0);
    step();
    check("R4 access after TRH", 32'(access_ok), 32'd1);
    rd_req = 1'b0; wr_req = 1'b0;

    // R6: idle qualified reset leaves record unchanged
    rst_pin_n = 1'b0;
    for (int i = 0; i < TRP + TRDY + 2; i++) step();
    rst_pin_n = 1'b1;
    for (int i = 0; i < TRH; i++) step();
    check("R6 idle keeps addr", 32'(corrupt_addr), 32'(cap));
    check("R4 access restored", 32'(access_ok), 32'd1);

    // normal completion, no abort
    start_op(1'b1, 20'h00010, 16'h0000);
    embed_done = 1'b1; step(); embed_done = 1'b0;
    check("R2 done clears busy", 32'(embed_busy), 32'd0);
    check("R2 no abort on done", 32'(embed_abort), 32'd0);

    // R6/R8: byte-mode op address with borrowed lsb
    start_op(1'b0, 20'hABCDE, 16'h8000);
    cap = {20'hABCDE, 1'b1};
    rst_pin_n = 1'b0;
    for (int i = 0; i < TRP; i++) step();
    check("R6 byte addr", 32'(corrupt_addr), 32'(cap));
    for (int i = 0; i < TRDY + 1; i++) step();
    rst_pin_n = 1'b1;
    for (int i = 0; i < TRH; i++) step();

    random_bus(40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule